// File: doc/BRIEF.md
# Timed-Transfer Parallel I/O Port

This block is an 8-bit bidirectional parallel port on a simple register bus. Every bit has its own direction, its own drive type (push-pull or open-drain) and its own choice between port data and an alternate output signal. Two low bits can also be taken over by a serial clock. When that serial clock is generated internally, the bit is forced to be an output.

Data written to the port is not sent to the pins at once. It first goes into a staging buffer. Each nibble then copies its half of that buffer into the pin output register on the rising edge of a transfer strobe chosen for that nibble. The strobe is either a half-rate system clock tick or one of three external timer pulses. Software can therefore write early and release the new pin values at a time set by a timer. A read of the data address returns the live pin levels.

Top module: `xfer_gpio`

## Requirements
- R1: After a synchronous active-low reset, every bit is an input (`pin_oe` = 0x00). The output register, the staging buffer and all configuration registers are cleared to zero.
- R2: A write to address 0x3F sets the direction of each bit: 1 makes the bit an output (`pin_oe` high) and 0 makes it an input (`pin_oe` low).
- R3: A write to address 0x38 loads only the staging buffer. A nibble of `pin_out` does not change until that nibble's selected strobe rises.
- R4: Address 0x3C holds the strobe selects. Bits 1:0 select the source for the low nibble and bits 5:4 select it for the high nibble. The codes are 00 for the half-rate tick, 01 for `tmr_a1`, 10 for `tmr_b1` and 11 for `tmr_b2`. After reset both fields are 00, so written data reaches the pins within two clock cycles.
- R5: With a timer selected, the transfer happens on the first clock edge at which that timer input is sampled high after being sampled low. This happens exactly once per pulse: data written while the timer input stays high waits for the next pulse.
- R6: The two nibbles transfer independently. A strobe selected only by one nibble updates only that nibble, and a pulse on an unselected timer changes nothing.
- R7: A write to address 0x3E sets open-drain mode per bit. For an output bit in this mode, `pin_oe` is high only while the driven value is 0. The setting has no effect on input bits.
- R8: A write to address 0x3D selects the alternate function per bit. A 1 drives `alt_out[i]` onto `pin_out[i]` in place of the port data, and a 0 drives the port data.
- R9: When `sclk_int_en[i]` is high for bit i in 0..1, that bit is driven as an output carrying `sclk_out[i]`, whatever its direction bit says.
- R10: `bus_rdata` returns `pin_in` combinationally while `bus_addr` is 0x38, and 0x00 at any other address.
- R11: Bits 7:6 and 3:2 of the control register are ignored. Setting them does not change which strobe either nibble uses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write enable, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (live pin levels at the data address) |
| tmr_a1 | input | 1 | Timer A1 output pulse |
| tmr_b1 | input | 1 | Timer B1 output pulse |
| tmr_b2 | input | 1 | Timer B2 output pulse |
| alt_out | input | 8 | Alternate output signal for each bit |
| sclk_out | input | 2 | Serial clock outputs for bits 0 and 1 |
| sclk_int_en | input | 2 | Internal serial clocking enable for bits 0 and 1 |
| pin_in | input | 8 | Sampled pad levels |
| pin_out | output | 8 | Value driven on each pad |
| pin_oe | output | 8 | Output enable for each pad |

## Verification
A register write takes effect at the clock edge that samples `bus_wr`. Direction, drive type and function selection therefore show on `pin_oe` and `pin_out` half a cycle later, and the bench samples them on the following falling edge. A timer transfer lands on the edge that first samples the pulse high, so the bench raises the timer on a falling edge and checks the pins on the next falling edge. Hold checks are taken several cycles after the write, while no pulse is applied. The half-rate path is checked three cycles after the write, which covers both phases of the tick. Reads of the pins are combinational and are checked in the same half cycle as the address change.

// File: rtl/xfer_gpio_pkg.sv
// Package: shared addresses and strobe source codes for the timed-transfer port.
// Assumes an 8-bit register address space; field strides are fixed per nibble.
package xfer_gpio_pkg;
    localparam int ADDR_W = 8;
    localparam logic [ADDR_W-1:0] ADDR_DATA  = 8'h38;
    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 8'h3C;
    localparam logic [ADDR_W-1:0] ADDR_FUNC  = 8'h3D;
    localparam logic [ADDR_W-1:0] ADDR_DRIVE = 8'h3E;
    localparam logic [ADDR_W-1:0] ADDR_DIR   = 8'h3F;

    localparam int N_SRC        = 4;
    localparam int CTRL_STRIDE  = 4;

    typedef enum logic [1:0] {
        SRC_HALF = 2'd0,
        SRC_TA1  = 2'd1,
        SRC_TB1  = 2'd2,
        SRC_TB2  = 2'd3
    } xfer_src_e;
endpackage

// File: rtl/xfer_gpio_regs.sv
// Module: configuration and staging registers of the port.
// Decodes bus writes into direction, drive, function, strobe-select and
// staging registers. Assumes single-cycle writes and synchronous reset.
module xfer_gpio_regs
    import xfer_gpio_pkg::*;
#(
    parameter int WIDTH   = 8,
    parameter int NIB_W   = 4,
    parameter int SEL_W   = 2,
    localparam int NIBBLES = WIDTH / NIB_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic                          bus_wr,
    input  logic [WIDTH-1:0]              bus_wdata,
    output logic [WIDTH-1:0]              dir_q,
    output logic [WIDTH-1:0]              drive_q,
    output logic [WIDTH-1:0]              func_q,
    output logic [WIDTH-1:0]              stage_q,
    output logic [NIBBLES-1:0][SEL_W-1:0] sel_q
);
    logic wr_dir, wr_drive, wr_func, wr_ctrl, wr_data;

    // Address decode of the write strobe.
    always_comb begin
        wr_dir   = bus_wr && (bus_addr == ADDR_DIR);
        wr_drive = bus_wr && (bus_addr == ADDR_DRIVE);
        wr_func  = bus_wr && (bus_addr == ADDR_FUNC);
        wr_ctrl  = bus_wr && (bus_addr == ADDR_CTRL);
        wr_data  = bus_wr && (bus_addr == ADDR_DATA);
    end

    // Per-bit configuration registers and the staging buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q   <= '0;
            drive_q <= '0;
            func_q  <= '0;
            stage_q <= '0;
        end else begin
            if (wr_dir)   dir_q   <= bus_wdata;
            if (wr_drive) drive_q <= bus_wdata;
            if (wr_func)  func_q  <= bus_wdata;
            if (wr_data)  stage_q <= bus_wdata;
        end
    end

    genvar n;
    generate
        for (n = 0; n < NIBBLES; n++) begin : g_sel
            // Strobe-select field for nibble n; other control bits are dropped.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sel_q[n] <= SEL_W'(SRC_HALF);
                end else if (wr_ctrl) begin
                    sel_q[n] <= bus_wdata[n*CTRL_STRIDE +: SEL_W];
                end
            end

            AST_CTRL_FIELD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
                wr_ctrl |=> (sel_q[n] == $past(bus_wdata[n*CTRL_STRIDE +: SEL_W]))); // R4
        end
    endgenerate

    AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> (dir_q == $past(bus_wdata))); // R2
endmodule

// File: rtl/xfer_gpio_strobe.sv
// Module: transfer strobe generation.
// Builds a half-rate tick, registers every strobe source, detects its rising
// edge and routes the selected edge to each nibble. Assumes timer pulses are
// synchronous to clk and at least one cycle low between pulses.
module xfer_gpio_strobe
    import xfer_gpio_pkg::*;
#(
    parameter int NIBBLES = 2,
    parameter int SEL_W   = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tmr_a1,
    input  logic                          tmr_b1,
    input  logic                          tmr_b2,
    input  logic [NIBBLES-1:0][SEL_W-1:0] sel_q,
    output logic [NIBBLES-1:0]            xfer
);
    logic             half_ph;
    logic [N_SRC-1:0] src_now;
    logic [N_SRC-1:0] src_q;
    logic [N_SRC-1:0] src_rise;

    // Half-rate phase toggle: rises every second clock.
    always_ff @(posedge clk) begin
        if (!rst_n) half_ph <= 1'b0;
        else        half_ph <= ~half_ph;
    end

    // Collect the sources in the order of their select codes.
    always_comb begin
        src_now[SRC_HALF] = half_ph;
        src_now[SRC_TA1]  = tmr_a1;
        src_now[SRC_TB1]  = tmr_b1;
        src_now[SRC_TB2]  = tmr_b2;
    end

    genvar s, n;
    generate
        for (s = 0; s < N_SRC; s++) begin : g_src
            // Previous-cycle sample of source s.
            always_ff @(posedge clk) begin
                if (!rst_n) src_q[s] <= 1'b0;
                else        src_q[s] <= src_now[s];
            end
            // Rising edge of source s seen at this clock.
            always_comb src_rise[s] = src_now[s] & ~src_q[s];
        end

        for (n = 0; n < NIBBLES; n++) begin : g_nib
            // Route the selected source edge to nibble n.
            always_comb xfer[n] = src_rise[sel_q[n]];

            AST_ONE_XFER_PER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
                (xfer[n] && $stable(sel_q[n])) |=> !xfer[n]); // R5
        end
    endgenerate
endmodule

// File: rtl/xfer_gpio_outreg.sv
// Module: per-nibble pin output register.
// Copies a nibble of the staging buffer into the output register when that
// nibble's transfer strobe is high; otherwise holds.
module xfer_gpio_outreg #(
    parameter int WIDTH   = 8,
    parameter int NIB_W   = 4,
    localparam int NIBBLES = WIDTH / NIB_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WIDTH-1:0]   stage_q,
    input  logic [NIBBLES-1:0] xfer,
    output logic [WIDTH-1:0]   out_q
);
    genvar n;
    generate
        for (n = 0; n < NIBBLES; n++) begin : g_nib
            // Load nibble n from the staging buffer on its strobe.
            always_ff @(posedge clk) begin
                if (!rst_n)       out_q[n*NIB_W +: NIB_W] <= '0;
                else if (xfer[n]) out_q[n*NIB_W +: NIB_W] <= stage_q[n*NIB_W +: NIB_W];
            end

            AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
                !xfer[n] |=> $stable(out_q[n*NIB_W +: NIB_W])); // R3
            AST_LOAD_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
                xfer[n] |=> (out_q[n*NIB_W +: NIB_W] == $past(stage_q[n*NIB_W +: NIB_W]))); // R5
        end
    endgenerate
endmodule

// File: rtl/xfer_gpio_pad.sv
// Module: per-bit pad drive logic.
// Picks the driven value (serial clock, alternate signal or port data) and
// the output enable (direction, serial-clock force, open-drain release).
module xfer_gpio_pad #(
    parameter int WIDTH     = 8,
    parameter int SCLK_BITS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [WIDTH-1:0]     dir_q,
    input  logic [WIDTH-1:0]     drive_q,
    input  logic [WIDTH-1:0]     func_q,
    input  logic [WIDTH-1:0]     out_q,
    input  logic [WIDTH-1:0]     alt_out,
    input  logic [SCLK_BITS-1:0] sclk_out,
    input  logic [SCLK_BITS-1:0] sclk_int_en,
    output logic [WIDTH-1:0]     pin_out,
    output logic [WIDTH-1:0]     pin_oe
);
    logic [WIDTH-1:0] force_out;
    logic [WIDTH-1:0] norm_val;
    logic [WIDTH-1:0] out_en;

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_bit
            if (i < SCLK_BITS) begin : g_sclk
                // Serial clock override for the low bits.
                always_comb begin
                    force_out[i] = sclk_int_en[i];
                    pin_out[i]   = sclk_int_en[i] ? sclk_out[i] : norm_val[i];
                end
            end else begin : g_plain
                // No serial clock on this bit.
                always_comb begin
                    force_out[i] = 1'b0;
                    pin_out[i]   = norm_val[i];
                end
            end

            // Port data or alternate signal.
            always_comb norm_val[i] = func_q[i] ? alt_out[i] : out_q[i];

            // Output enable with open-drain release of a driven 1.
            always_comb begin
                out_en[i] = dir_q[i] | force_out[i];
                pin_oe[i] = out_en[i] & ~(drive_q[i] & pin_out[i]);
            end

            AST_OPEN_DRAIN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
                (drive_q[i] && pin_out[i]) |-> !pin_oe[i]); // R7
            AST_INPUT_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
                (!dir_q[i] && !force_out[i]) |-> !pin_oe[i]); // R2
        end
    endgenerate
endmodule

// File: rtl/xfer_gpio.sv
// Module: timed-transfer parallel I/O port, top level.
// Joins the register file, strobe generator, output register and pad logic,
// and returns live pin levels on reads of the data address.
module xfer_gpio
    import xfer_gpio_pkg::*;
#(
    parameter int WIDTH     = 8,
    parameter int NIB_W     = 4,
    parameter int SEL_W     = 2,
    parameter int SCLK_BITS = 2,
    localparam int NIBBLES  = WIDTH / NIB_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [WIDTH-1:0]     bus_wdata,
    output logic [WIDTH-1:0]     bus_rdata,
    input  logic                 tmr_a1,
    input  logic                 tmr_b1,
    input  logic                 tmr_b2,
    input  logic [WIDTH-1:0]     alt_out,
    input  logic [SCLK_BITS-1:0] sclk_out,
    input  logic [SCLK_BITS-1:0] sclk_int_en,
    input  logic [WIDTH-1:0]     pin_in,
    output logic [WIDTH-1:0]     pin_out,
    output logic [WIDTH-1:0]     pin_oe
);
    logic [WIDTH-1:0]              dir_q, drive_q, func_q, stage_q, out_q;
    logic [NIBBLES-1:0][SEL_W-1:0] sel_q;
    logic [NIBBLES-1:0]            xfer;

    xfer_gpio_regs #(.WIDTH(WIDTH), .NIB_W(NIB_W), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .dir_q(dir_q), .drive_q(drive_q),
        .func_q(func_q), .stage_q(stage_q), .sel_q(sel_q)
    );

    xfer_gpio_strobe #(.NIBBLES(NIBBLES), .SEL_W(SEL_W)) u_strobe (
        .clk(clk), .rst_n(rst_n), .tmr_a1(tmr_a1), .tmr_b1(tmr_b1),
        .tmr_b2(tmr_b2), .sel_q(sel_q), .xfer(xfer)
    );

    xfer_gpio_outreg #(.WIDTH(WIDTH), .NIB_W(NIB_W)) u_outreg (
        .clk(clk), .rst_n(rst_n), .stage_q(stage_q), .xfer(xfer), .out_q(out_q)
    );

    xfer_gpio_pad #(.WIDTH(WIDTH), .SCLK_BITS(SCLK_BITS)) u_pad (
        .clk(clk), .rst_n(rst_n), .dir_q(dir_q), .drive_q(drive_q),
        .func_q(func_q), .out_q(out_q), .alt_out(alt_out),
        .sclk_out(sclk_out), .sclk_int_en(sclk_int_en),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // Read path: live pins at the data address, zero elsewhere.
    always_comb bus_rdata = (bus_addr == ADDR_DATA) ? pin_in : '0;

    AST_READ_LIVE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_DATA) |-> (bus_rdata == pin_in)); // R10
endmodule

// File: tb/tb_xfer_gpio.sv
`timescale 1ns/1ps
module tb_xfer_gpio;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       tmr_a1 = 1'b0, tmr_b1 = 1'b0, tmr_b2 = 1'b0;
    logic [7:0] alt_out = 8'h00;
    logic [1:0] sclk_out = 2'b00, sclk_int_en = 2'b00;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_out, pin_oe;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    xfer_gpio dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_a1(tmr_a1),
        .tmr_b1(tmr_b1), .tmr_b2(tmr_b2), .alt_out(alt_out),
        .sclk_out(sclk_out), .sclk_int_en(sclk_int_en), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 8'h00;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 oe after reset", pin_oe, 8'h00);
        check("R1 out after reset", pin_out, 8'h00);
    endtask

    task automatic t_dir;
        wr(8'h3F, 8'hFF);
        check("R2 all outputs", pin_oe, 8'hFF);
        wr(8'h3F, 8'h3C);
        check("R2 mixed direction", pin_oe, 8'h3C);
        wr(8'h3F, 8'hFF);
    endtask

    task automatic t_half;
        wr(8'h38, 8'hA5);
        idle(2);
        check("R4 default half-rate transfer", pin_out, 8'hA5);
    endtask

    task automatic t_timer;
        wr(8'h3C, 8'h11);
        wr(8'h38, 8'h3C);
        idle(5);
        check("R3 held before strobe", pin_out, 8'hA5);
        tmr_a1 = 1'b1;
        @(negedge clk);
        check("R5 transfer on timer rise", pin_out, 8'h3C);
        wr(8'h38, 8'h77);
        idle(3);
        check("R5 no second transfer while high", pin_out, 8'h3C);
        tmr_a1 = 1'b0;
        idle(2);
        tmr_a1 = 1'b1;
        @(negedge clk);
        tmr_a1 = 1'b0;
        check("R5 next pulse transfers", pin_out, 8'h77);
    endtask

    task automatic t_nibbles;
        wr(8'h3C, 8'h32);
        wr(8'h38, 8'h12);
        tmr_a1 = 1'b1;
        @(negedge clk);
        tmr_a1 = 1'b0;
        idle(1);
        check("R6 unselected timer ignored", pin_out, 8'h77);
        tmr_b1 = 1'b1;
        @(negedge clk);
        tmr_b1 = 1'b0;
        check("R6 low nibble only", pin_out, 8'h72);
        idle(1);
        tmr_b2 = 1'b1;
        @(negedge clk);
        tmr_b2 = 1'b0;
        check("R6 high nibble follows", pin_out, 8'h12);
    endtask

    task automatic t_ignored_bits;
        wr(8'h3C, 8'hCD);
        wr(8'h38, 8'h99);
        idle(3);
        check("R11 high half-rate low held", pin_out, 8'h92);
        tmr_a1 = 1'b1;
        @(negedge clk);
        tmr_a1 = 1'b0;
        check("R11 low nibble on timer A1", pin_out, 8'h99);
    endtask

    task automatic t_open_drain;
        wr(8'h3E, 8'h0F);
        check("R7 open-drain low nibble", pin_oe, 8'hF6);
        wr(8'h3F, 8'hF0);
        check("R7 no effect on inputs", pin_oe, 8'hF0);
        wr(8'h3F, 8'hFF);
        wr(8'h3E, 8'h00);
        check("R7 push-pull restored", pin_oe, 8'hFF);
    endtask

    task automatic t_func;
        alt_out = 8'h5A;
        wr(8'h3D, 8'hF0);
        check("R8 alternate high nibble", pin_out, 8'h59);
        alt_out = 8'hA5;
        @(negedge clk);
        check("R8 alternate follows input", pin_out, 8'hA9);
    endtask

    task automatic t_sclk;
        wr(8'h3F, 8'h00);
        sclk_out = 2'b01; sclk_int_en = 2'b01;
        @(negedge clk);
        check("R9 forced output oe", pin_oe, 8'h01);
        check("R9 serial clock high", {7'b0, pin_out[0]}, 8'h01);
        sclk_out = 2'b00;
        @(negedge clk);
        check("R9 serial clock low", {7'b0, pin_out[0]}, 8'h00);
        sclk_int_en = 2'b00;
        @(negedge clk);
        check("R9 released", pin_oe, 8'h00);
    endtask

    task automatic t_read;
        pin_in = 8'hC3;
        bus_addr = 8'h38;
        #1;
        check("R10 read live pins", bus_rdata, 8'hC3);
        pin_in = 8'h3E;
        #1;
        check("R10 read follows pins", bus_rdata, 8'h3E);
        bus_addr = 8'h3F;
        #1;
        check("R10 other address reads zero", bus_rdata, 8'h00);
        bus_addr = 8'h00;
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_dir();
        t_half();
        t_timer();
        t_nibbles();
        t_ignored_bits();
        t_open_drain();
        t_func();
        t_sclk();
        t_read();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule